// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device-side virtual address into a physical address by reading descriptors from a two-level translation table kept in memory. A client presents a request (virtual address plus a write flag) while the walker is idle; the walker latches the request together with the current table base, then fetches one or two descriptors over a simple memory read port. Each read is a one-cycle request pulse with an address, answered later by a one-cycle valid pulse that carries the data.

The first-level descriptor either maps a 1 MB region directly, points to a second-level table, or faults. A second-level descriptor maps a 64 KB or a 4 KB page, or faults. The walker ends every walk with a one-cycle response that carries either the translated physical address or a fault flag, together with the faulting virtual address and its direction.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: The first read of a walk goes to `tbl_base + va[31:20]*4`, using the base present in the cycle the request was accepted.
- R3: A first-level descriptor with bits [1:0] = 2 ends the walk after exactly one read with physical address `{desc[31:20], va[19:0]}` and no fault.
- R4: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk after one read with `rsp_fault` = 1, `rsp_pa` = 0, `rsp_fault_va` equal to the request address and `rsp_fault_write` equal to the request's write flag.
- R5: A first-level descriptor with bits [1:0] = 1 causes a second read at address `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor with bits [1:0] = 1 gives physical address `{desc[31:16], va[15:0]}` after exactly two reads.
- R7: A second-level descriptor with bit 1 set (bits [1:0] = 2 or 3) gives physical address `{desc[31:12], va[11:0]}`.
- R8: A second-level descriptor with bits [1:0] = 0 ends the walk after two reads with a fault carrying the request address and direction, and `rsp_pa` = 0.
- R9: Only one walk is in flight: `req_ready` is 0 from acceptance until the response cycle has passed, and requests presented meanwhile are dropped without effect on the result or the read count.
- R10: `rsp_valid` is a single-cycle pulse in the cycle after the last descriptor's `mem_valid`; `mem_req` is a single-cycle pulse per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ready | output | 1 | Walker idle; request accepted when both high |
| tbl_base | input | 32 | First-level table base address |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor address |
| mem_valid | input | 1 | Descriptor data valid pulse |
| mem_rdata | input | 32 | Descriptor data |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_va | output | 32 | Faulting virtual address (0 when no fault) |
| rsp_fault_write | output | 1 | Direction of the faulting access |

## Verification
With a memory latency of L cycles between a read pulse and its data, a walk ending at level one reports L+2 cycles after the request is driven and a two-read walk reports 2L+3 cycles after. The bench counts falling edges from the request to the first sampled `rsp_valid` and compares the count with these figures, then checks that the pulse is gone one cycle later. Read addresses and the number of reads are logged by the memory model at the falling edge on which each request pulse is seen, and compared after the response.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int AW          = 32;
    localparam int L1_IDX_LSB  = 20;
    localparam int L2_IDX_LSB  = 12;
    localparam int LARGE_LSB   = 16;
    localparam int L2_BASE_LSB = 10;
    localparam int L1_IDX_W    = AW - L1_IDX_LSB;
    localparam int L2_IDX_W    = L1_IDX_LSB - L2_IDX_LSB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        DK_FAULT,
        DK_TABLE,
        DK_LEAF
    } desc_kind_e;

    typedef struct packed {
        walk_st_e        st;
        logic [AW-1:0]   va;
        logic            wr;
        logic [AW-1:0]   base;
        logic [AW-1:0]   l2_base;
        logic [AW-1:0]   pa;
        logic            fault;
    } walk_state_t;

endpackage

// File: rtl/pt_desc_addr.sv
module pt_desc_addr
    import pt_walker_pkg::*;
(
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] l2_base,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] l1_addr,
    output logic [AW-1:0] l2_addr
);
    logic [AW-1:0] l1_off;
    logic [AW-1:0] l2_off;
    logic          unused_bits;

    assign l1_off  = {{(AW-L1_IDX_W-2){1'b0}}, va[AW-1:L1_IDX_LSB], 2'b00};
    assign l2_off  = {{(AW-L2_IDX_W-2){1'b0}}, va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
    assign l1_addr = base + l1_off;
    assign l2_addr = {l2_base[AW-1:L2_BASE_LSB], l2_off[L2_BASE_LSB-1:0]};

    assign unused_bits = ^{va[L2_IDX_LSB-1:0], l2_base[L2_BASE_LSB-1:0]};
endmodule

// File: rtl/pt_desc_decode.sv
module pt_desc_decode
    import pt_walker_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] va,
    output desc_kind_e    kind,
    output logic [AW-1:0] pa
);
    generate
        if (LEVEL == 1) begin : g_first
            logic unused_bits;
            assign unused_bits = ^desc[L1_IDX_LSB-1:2];
            always_comb begin
                kind = DK_FAULT;
                pa   = '0;
                unique case (desc[1:0])
                    2'd2: begin
                        kind = DK_LEAF;
                        pa   = {desc[AW-1:L1_IDX_LSB], va[L1_IDX_LSB-1:0]};
                    end
                    2'd1:    kind = DK_TABLE;
                    default: kind = DK_FAULT;
                endcase
            end
        end else begin : g_second
            logic unused_bits;
            assign unused_bits = ^desc[L2_IDX_LSB-1:2];
            always_comb begin
                kind = DK_FAULT;
                pa   = '0;
                if (desc[1]) begin
                    kind = DK_LEAF;
                    pa   = {desc[AW-1:L2_IDX_LSB], va[L2_IDX_LSB-1:0]};
                end else if (desc[0]) begin
                    kind = DK_LEAF;
                    pa   = {desc[AW-1:LARGE_LSB], va[LARGE_LSB-1:0]};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [31:0]   req_va,
    input  logic          req_write,
    output logic          req_ready,
    input  logic [31:0]   tbl_base,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_rdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_pa,
    output logic          rsp_fault,
    output logic [31:0]   rsp_fault_va,
    output logic          rsp_fault_write
);
    walk_state_t q, d;

    logic [AW-1:0] l1_addr, l2_addr;
    logic [AW-1:0] l1_pa, l2_pa;
    desc_kind_e    l1_kind, l2_kind;

    pt_desc_addr u_addr (
        .base    (q.base),
        .l2_base (q.l2_base),
        .va      (q.va),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    pt_desc_decode #(.LEVEL(1)) u_dec_l1 (
        .desc (mem_rdata),
        .va   (q.va),
        .kind (l1_kind),
        .pa   (l1_pa)
    );

    pt_desc_decode #(.LEVEL(2)) u_dec_l2 (
        .desc (mem_rdata),
        .va   (q.va),
        .kind (l2_kind),
        .pa   (l2_pa)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st      = ST_L1_ISSUE;
                    d.va      = req_va;
                    d.wr      = req_write;
                    d.base    = tbl_base;
                    d.l2_base = '0;
                    d.pa      = '0;
                    d.fault   = 1'b0;
                end
            end
            ST_L1_ISSUE: d.st = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_valid) begin
                    unique case (l1_kind)
                        DK_LEAF: begin
                            d.pa = l1_pa;
                            d.st = ST_DONE;
                        end
                        DK_TABLE: begin
                            d.l2_base = {mem_rdata[AW-1:L2_BASE_LSB], {L2_BASE_LSB{1'b0}}};
                            d.st      = ST_L2_ISSUE;
                        end
                        default: begin
                            d.fault = 1'b1;
                            d.st    = ST_DONE;
                        end
                    endcase
                end
            end
            ST_L2_ISSUE: d.st = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_valid) begin
                    if (l2_kind == DK_LEAF) d.pa = l2_pa;
                    else                    d.fault = 1'b1;
                    d.st = ST_DONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready       = (q.st == ST_IDLE);
    assign mem_req         = (q.st == ST_L1_ISSUE) || (q.st == ST_L2_ISSUE);
    assign mem_addr        = (q.st == ST_L2_ISSUE || q.st == ST_L2_WAIT) ? l2_addr : l1_addr;
    assign rsp_valid       = (q.st == ST_DONE);
    assign rsp_pa          = rsp_valid ? q.pa : '0;
    assign rsp_fault       = rsp_valid && q.fault;
    assign rsp_fault_va    = rsp_fault ? q.va : '0;
    assign rsp_fault_write = rsp_fault && q.wr;
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic        req_write,
    input logic        req_ready,
    input logic [31:0] tbl_base,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        rsp_valid,
    input logic [31:0] rsp_pa,
    input logic        rsp_fault,
    input logic [31:0] rsp_fault_va,
    input logic        rsp_fault_write
);
    logic [31:0] seen_va;
    logic        seen_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_va <= '0;
            seen_wr <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen_va <= req_va;
            seen_wr <= req_write;
        end
    end

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_req && mem_addr == $past(tbl_base + {18'b0, req_va[31:20], 2'b00})));

    assert_fault_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |->
            (rsp_pa == 32'b0 && rsp_fault_va == seen_va && rsp_fault_write == seen_wr));

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_mem_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_rsp_follows_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(mem_valid));
endmodule

bind pt_walker pt_walker_checker u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_va          (req_va),
    .req_write       (req_write),
    .req_ready       (req_ready),
    .tbl_base        (tbl_base),
    .mem_req         (mem_req),
    .mem_addr        (mem_addr),
    .mem_valid       (mem_valid),
    .rsp_valid       (rsp_valid),
    .rsp_pa          (rsp_pa),
    .rsp_fault       (rsp_fault),
    .rsp_fault_va    (rsp_fault_va),
    .rsp_fault_write (rsp_fault_write)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int LAT_ONE    = MEM_LAT + 2;
    localparam int LAT_TWO    = 2 * MEM_LAT + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic [31:0] tbl_base = 32'h0001_0000;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic [31:0] rsp_fault_va;
    logic        rsp_fault_write;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem [logic [31:0]];
    int          nreads = 0;
    logic [31:0] addr_log [0:7];
    bit          pend = 1'b0;
    int          cd = 0;
    logic [31:0] pend_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_va          (req_va),
        .req_write       (req_write),
        .req_ready       (req_ready),
        .tbl_base        (tbl_base),
        .mem_req         (mem_req),
        .mem_addr        (mem_addr),
        .mem_valid       (mem_valid),
        .mem_rdata       (mem_rdata),
        .rsp_valid       (rsp_valid),
        .rsp_pa          (rsp_pa),
        .rsp_fault       (rsp_fault),
        .rsp_fault_va    (rsp_fault_va),
        .rsp_fault_write (rsp_fault_write)
    );

    // Memory model: read seen on a falling edge returns MEM_LAT falling edges later.
    always @(negedge clk) begin
        mem_valid = 1'b0;
        if (pend) begin
            if (cd == 1) begin
                mem_valid = 1'b1;
                mem_rdata = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
                pend = 1'b0;
            end else begin
                cd = cd - 1;
            end
        end
        if (mem_req) begin
            pend = 1'b1;
            cd = MEM_LAT;
            pend_addr = mem_addr;
            if (nreads < 8) addr_log[nreads] = mem_addr;
            nreads = nreads + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input bit wr, input bit exp_fault,
                            input logic [31:0] exp_pa, input int exp_reads, input int exp_lat,
                            input logic [31:0] exp_a0, input logic [31:0] exp_a1,
                            input string tag, input bit poke_busy);
        int lat;
        @(negedge clk);
        nreads = 0;
        req_va = va;
        req_write = wr;
        req_valid = 1'b1;
        lat = 0;
        @(negedge clk);
        lat++;
        req_valid = 1'b0;
        if (poke_busy) begin
            chk(req_ready == 1'b0, {tag, " R9 ready low while busy"}, {31'b0, req_ready}, 32'd0);
            req_va = ~va;
            req_write = ~wr;
            req_valid = 1'b1;
        end
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
            if (poke_busy && lat == 3) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        chk(lat == exp_lat, {tag, " R10 latency"}, lat, exp_lat);
        chk(rsp_fault == exp_fault, {tag, " fault flag"}, {31'b0, rsp_fault}, {31'b0, exp_fault});
        chk(rsp_pa == (exp_fault ? 32'h0 : exp_pa), {tag, " physical address"}, rsp_pa, exp_fault ? 32'h0 : exp_pa);
        if (exp_fault) begin
            chk(rsp_fault_va == va, {tag, " fault va"}, rsp_fault_va, va);
            chk(rsp_fault_write == wr, {tag, " fault dir"}, {31'b0, rsp_fault_write}, {31'b0, wr});
        end
        chk(nreads == exp_reads, {tag, " read count"}, nreads, exp_reads);
        chk(addr_log[0] == exp_a0, {tag, " R2 first read addr"}, addr_log[0], exp_a0);
        if (exp_reads == 2)
            chk(addr_log[1] == exp_a1, {tag, " R5 second read addr"}, addr_log[1], exp_a1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R10 single pulse"}, {31'b0, rsp_valid}, 32'd0);
        repeat (3) @(negedge clk);
        chk(nreads == exp_reads && rsp_valid == 1'b0, {tag, " R9 no extra walk"}, nreads, exp_reads);
    endtask

    function automatic logic [31:0] l1a(input logic [31:0] va);
        return tbl_base + {18'b0, va[31:20], 2'b00};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk(mem_req == 1'b0, "R1 no read after reset", {31'b0, mem_req}, 32'd0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_section();
        logic [31:0] va = 32'h1234_5678;
        mem[l1a(va)] = 32'hABC0_0002;
        run_walk(va, 1'b0, 1'b0, 32'hABC4_5678, 1, LAT_ONE, l1a(va), 0, "R3 section", 1'b0);
    endtask

    task automatic t_l1_faults();
        logic [31:0] va0 = 32'h4440_0ABC;
        logic [31:0] va3 = 32'h5550_0DEF;
        mem[l1a(va0)] = 32'hFFF0_0000;
        mem[l1a(va3)] = 32'hFFF0_0003;
        run_walk(va0, 1'b1, 1'b1, 0, 1, LAT_ONE, l1a(va0), 0, "R4 type0 fault", 1'b0);
        run_walk(va3, 1'b0, 1'b1, 0, 1, LAT_ONE, l1a(va3), 0, "R4 type3 fault", 1'b0);
    endtask

    task automatic t_pages();
        logic [31:0] va = 32'h0056_789A;
        logic [31:0] l2a = 32'h0040_059C;
        mem[l1a(va)] = 32'h0040_07FD;
        mem[l2a] = 32'h7777_0001;
        run_walk(va, 1'b0, 1'b0, 32'h7777_789A, 2, LAT_TWO, l1a(va), l2a, "R6 large page", 1'b0);
        mem[l2a] = 32'h8888_9002;
        run_walk(va, 1'b0, 1'b0, 32'h8888_989A, 2, LAT_TWO, l1a(va), l2a, "R7 small page type2", 1'b0);
        mem[l2a] = 32'h8888_9003;
        run_walk(va, 1'b1, 1'b0, 32'h8888_989A, 2, LAT_TWO, l1a(va), l2a, "R7 small page type3", 1'b0);
        mem[l2a] = 32'h9999_F000;
        run_walk(va, 1'b1, 1'b1, 0, 2, LAT_TWO, l1a(va), l2a, "R8 second-level fault", 1'b0);
    endtask

    task automatic t_busy();
        logic [31:0] va = 32'h1234_5678;
        run_walk(va, 1'b0, 1'b0, 32'hABC4_5678, 1, LAT_ONE, l1a(va), 0, "R9 busy drop", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_section();
        t_l1_faults();
        t_pages();
        t_busy();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule